// File: doc/BRIEF.md
# DMA Burst Register Mapper

This block sits inside a peripheral and lets a DMA engine load or read a run of consecutive internal registers through one fixed buffer location. The buffer holds no data of its own. Every write to it lands in an internal register, and every read of it returns an internal register. Which register is used depends on a start offset and on how far the current burst has advanced.

An internal event starts a burst, but only if its enable bit is set. The block then raises a DMA request once for each transfer in the burst. With a transfer count of N the burst has N+1 transfers. The first transfer targets the start offset, and each acknowledged transfer moves the target up by one word, which is a byte step of 0x4.

The controller has three states:
- ST_IDLE waits for an enabled event. On one it takes ST_IDLE→ST_REQ and latches the start offset and the count.
- ST_REQ holds the request high until an acknowledge arrives. It then takes ST_REQ→ST_GAP if transfers remain, or ST_REQ→ST_IDLE after the last one.
- ST_GAP drops the request for one cycle and always takes ST_GAP→ST_REQ.

Top module: `burst_reg_mapper`

## Requirements
- R1: After reset, `dma_req` is low and every internal register reads 0.
- R2: A burst starts only in ST_IDLE, and only when some `evt_in` bit is high and its `cfg_evt_en` bit is also set. An event whose enable bit is clear raises no request.
- R3: With `cfg_count` = N, one event produces exactly N+1 acknowledged requests, and then no further request. A count of 0 gives a single request.
- R4: Transfer k of a burst (k starting at 0) targets word index `cfg_base`+k, which is byte offset 4·(`cfg_base`+k). For N=3 the byte offsets are base+0x0, +0x4, +0x8 and +0xC.
- R5: The cycle after an acknowledged transfer that is not the last, `dma_req` is low for exactly one cycle and is then raised again.
- R6: An event that arrives while a burst is in progress, in ST_REQ or ST_GAP, is ignored. It adds no request.
- R7: If the word index reaches `NREG` or more, a write is dropped and a read returns 0. Nothing wraps around.
- R8: Every new burst starts again at the start offset latched from `cfg_base` when that burst is triggered.
- R9: In ST_IDLE, a buffer access targets word index `cfg_base` and does not advance the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | OW | Start word index |
| cfg_count | input | CW | Transfers minus one |
| cfg_evt_en | input | NEVT | Enable mask for DMA-triggering events |
| evt_in | input | NEVT | Internal event pulses |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge; high in the same cycle as the buffer access |
| buf_wr | input | 1 | Write strobe for the buffer address |
| buf_rd | input | 1 | Read strobe for the buffer address |
| buf_wdata | input | DW | Buffer write data |
| buf_rdata | output | DW | Buffer read data, combinational |
| regs_o | output | NREG·DW | Internal register file contents, register i at bits [i·DW +: DW] |

## Verification
The bench counts requests per burst. An off-by-one in the last-transfer compare would show up as N or N+2 requests, and a count of zero would hang or repeat. It starts bursts near the top of the register file. A design that wrapped the index or failed to gate writes would corrupt the low registers, which the bench sees on `regs_o`, and an out-of-range read would return stale data instead of 0. It also fires enabled events in the middle of bursts, and issues back-to-back bursts with new offsets. A design that restarted on such an event, or that did not reload the start offset for a new burst, would show extra requests or data in the wrong register.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } bst_e;
endpackage

// File: rtl/bmap_seq.sv
module bmap_seq
    import bmap_pkg::*;
#(
    parameter int NEVT = 4,
    parameter int CW   = 4,
    parameter int OW   = 4,
    parameter int SW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OW-1:0]   cfg_base,
    input  logic [CW-1:0]   cfg_count,
    input  logic [NEVT-1:0] cfg_evt_en,
    input  logic [NEVT-1:0] evt_in,
    input  logic            dma_ack,
    output logic            dma_req,
    output logic [SW-1:0]   cur_off,
    output bst_e            st
);
    bst_e          st_q, st_d;
    logic [CW-1:0] idx, cnt_lat;
    logic [OW-1:0] base_lat;
    logic          trig, last;

    assign trig = |(evt_in & cfg_evt_en);
    assign last = (idx == cnt_lat);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (trig)    st_d = ST_REQ;
            ST_REQ:  if (dma_ack) st_d = last ? ST_IDLE : ST_GAP;
            ST_GAP:               st_d = ST_REQ;
            default:              st_d = ST_IDLE;
        endcase
    end

    // burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            cnt_lat  <= '0;
            base_lat <= '0;
        end else if (st_q == ST_IDLE && trig) begin
            idx      <= '0;
            cnt_lat  <= cfg_count;
            base_lat <= cfg_base;
        end else if (st_q == ST_REQ && dma_ack) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        dma_req = (st_q == ST_REQ);
        if (st_q == ST_IDLE) cur_off = SW'(cfg_base);
        else                 cur_off = SW'(base_lat) + SW'(idx);
        st = st_q;
    end
endmodule

// File: rtl/bmap_regfile.sv
module bmap_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int SW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   off,
    input  logic            wr,
    input  logic            rd,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [NREG*DW-1:0] regs_o
);
    logic [DW-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        mem[g] <= '0;
            else if (wr && off == SW'(g))      mem[g] <= wdata;
        end
        assign regs_o[g*DW +: DW] = mem[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (rd && off == SW'(i)) rdata = mem[i];
    end
endmodule

// File: rtl/burst_reg_mapper.sv
module burst_reg_mapper
    import bmap_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int NEVT = 4,
    parameter int CW   = 4,
    parameter int OW   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OW-1:0]      cfg_base,
    input  logic [CW-1:0]      cfg_count,
    input  logic [NEVT-1:0]    cfg_evt_en,
    input  logic [NEVT-1:0]    evt_in,
    output logic               dma_req,
    input  logic               dma_ack,
    input  logic               buf_wr,
    input  logic               buf_rd,
    input  logic [DW-1:0]      buf_wdata,
    output logic [DW-1:0]      buf_rdata,
    output logic [NREG*DW-1:0] regs_o
);
    localparam int SW = ((OW > CW) ? OW : CW) + 1;

    logic [SW-1:0] cur_off;
    bst_e          st;

    bmap_seq #(.NEVT(NEVT), .CW(CW), .OW(OW), .SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_count(cfg_count),
        .cfg_evt_en(cfg_evt_en), .evt_in(evt_in), .dma_ack(dma_ack),
        .dma_req(dma_req), .cur_off(cur_off), .st(st)
    );

    bmap_regfile #(.NREG(NREG), .DW(DW), .SW(SW)) u_rf (
        .clk(clk), .rst_n(rst_n), .off(cur_off), .wr(buf_wr), .rd(buf_rd),
        .wdata(buf_wdata), .rdata(buf_rdata), .regs_o(regs_o)
    );
endmodule

// File: rtl/bmap_chk.sv
module bmap_chk
    import bmap_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int NEVT = 4,
    parameter int SW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NEVT-1:0] cfg_evt_en,
    input logic [NEVT-1:0] evt_in,
    input logic            dma_req,
    input logic            dma_ack,
    input logic            buf_rd,
    input logic [DW-1:0]   buf_rdata,
    input logic [SW-1:0]   cur_off,
    input bst_e            st
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !dma_req);

    a_r2_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !(|(evt_in & cfg_evt_en))) |=> !dma_req);

    a_r5_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req);

    a_r5_req_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |=> dma_req);

    a_r6_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !(dma_req && dma_ack)) |=> $stable(cur_off));

    a_r7_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && cur_off >= SW'(NREG)) |-> buf_rdata == '0);
endmodule

bind burst_reg_mapper bmap_chk #(.NREG(NREG), .DW(DW), .NEVT(NEVT), .SW(SW)) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_evt_en(cfg_evt_en), .evt_in(evt_in),
    .dma_req(dma_req), .dma_ack(dma_ack), .buf_rd(buf_rd),
    .buf_rdata(buf_rdata), .cur_off(cur_off), .st(st)
);

// File: tb/test_burst_reg_mapper.sv
module test_burst_reg_mapper;
    localparam int CLK_P = 10;
    localparam int NREG = 8, DW = 16, NEVT = 4, CW = 4, OW = 4;

    logic clk = 0, rst_n = 0;
    logic [OW-1:0] cfg_base = 0;
    logic [CW-1:0] cfg_count = 0;
    logic [NEVT-1:0] cfg_evt_en = 4'b0101, evt_in = 0;
    logic dma_req, dma_ack = 0, buf_wr = 0, buf_rd = 0;
    logic [DW-1:0] buf_wdata = 0, buf_rdata;
    logic [NREG*DW-1:0] regs_o;

    logic [DW-1:0] exp_mem [NREG];
    int n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    burst_reg_mapper #(.NREG(NREG), .DW(DW), .NEVT(NEVT), .CW(CW), .OW(OW)) i_burst_reg_mapper (.*);

    function automatic logic [DW-1:0] exp_rd(int off);
        return (off < NREG) ? exp_mem[off] : '0;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(string req);
        for (int i = 0; i < NREG; i++)
            check(regs_o[i*DW +: DW] == exp_mem[i], req, 32'(regs_o[i*DW +: DW]), 32'(exp_mem[i]));
    endtask

    task automatic no_req(int cyc, string req);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (dma_req) seen++;
        end
        check(seen == 0, req, 32'(seen), 0);
    endtask

    // one burst: trigger, serve every request, then confirm silence
    task automatic burst(int base, int cnt, bit rd, bit mid_evt);
        int got = 0;
        bit hung = 0;
        @(negedge clk);
        cfg_base = OW'(base); cfg_count = CW'(cnt); evt_in = 4'b0100;
        @(negedge clk);
        evt_in = 0;
        for (int k = 0; k <= cnt && !hung; k++) begin
            int w = 0;
            while (!dma_req && w < 20) begin @(negedge clk); w++; end
            if (!dma_req) begin hung = 1; break; end
            got++;
            dma_ack = 1;
            if (rd) begin
                buf_rd = 1; #1;
                check(buf_rdata == exp_rd(base + k), (k == 0) ? "R8" : (base + k >= NREG ? "R7" : "R4"),
                      32'(buf_rdata), 32'(exp_rd(base + k)));
            end else begin
                buf_wr = 1; buf_wdata = DW'($urandom);
                if (base + k < NREG) exp_mem[base + k] = buf_wdata;
            end
            if (mid_evt && k == 0) evt_in = 4'b0001;
            @(negedge clk);
            dma_ack = 0; buf_wr = 0; buf_rd = 0; evt_in = 0;
            if (k < cnt) check(!dma_req, "R5", 32'(dma_req), 0);
        end
        check(got == cnt + 1, mid_evt ? "R6" : "R3", 32'(got), 32'(cnt + 1));
        no_req(6, "R3");
        check_regs(base + cnt >= NREG ? "R7" : "R4");
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < NREG; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!dma_req, "R1", 32'(dma_req), 0);
        check_regs("R1");

        // disabled event bit 1 must not start
        evt_in = 4'b0010;
        @(negedge clk);
        evt_in = 0;
        no_req(5, "R2");

        burst(3, 0, 0, 0);      // single transfer
        burst(2, 3, 0, 0);      // offsets base+0x0..0xC
        burst(2, 3, 1, 0);      // read back, restart at base
        burst(6, 3, 0, 0);      // runs past the end
        burst(6, 3, 1, 0);      // reads beyond end give zero
        burst(0, 4, 0, 1);      // event mid burst

        // idle access goes to cfg_base, no advance
        @(negedge clk);
        cfg_base = 4'd1; buf_wr = 1; buf_wdata = 16'hA5A5; exp_mem[1] = 16'hA5A5;
        @(negedge clk);
        buf_wdata = 16'h3C3C; exp_mem[1] = 16'h3C3C;
        @(negedge clk);
        buf_wr = 0;
        check(regs_o[1*DW +: DW] == 16'h3C3C, "R9", 32'(regs_o[1*DW +: DW]), 32'h3C3C);
        check(regs_o[2*DW +: DW] == exp_mem[2], "R9", 32'(regs_o[2*DW +: DW]), 32'(exp_mem[2]));
        buf_rd = 1; #1;
        check(buf_rdata == 16'h3C3C, "R9", 32'(buf_rdata), 32'h3C3C);
        @(negedge clk);
        buf_rd = 0;

        for (int t = 0; t < 24; t++)
            burst(int'($urandom_range(0, 11)), int'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule